// File: doc/BRIEF.md
# Maskable Interrupt Priority Resolver

This block sits between the per-group interrupt state of an interrupt controller and the processor. Every cycle it scans the maskable groups, treats a group as pending when any of its request bits is set together with the matching enable bit, and picks the pending group with the numerically lowest 3-bit level. That level is sent to the processor through a register. When nothing qualifies, the idle level 7 is sent.

When the processor takes an interrupt, it pulses an acknowledge together with the level it believes it is serving. The block then stores the number of the group that is winning at that moment. Software reads the stored value back through a small byte-addressed read port. The block also watches the non-maskable groups and sends out a single-cycle pulse when an input event arrives on one of them while that group has an enabled request.

Group g owns bits `[4g+3:4g]` of the request and enable vectors and bits `[3g+2:3g]` of the level vector. Groups 0 and 1 are the non-maskable groups. Groups 2 to 30 are maskable.

Top module: `irq_pri_resolver`

## Requirements
- R1: After reset, `level_o` is 7 and `nmi_o` is 0. `ack_err_o` is 0 and `rd_data_o` reads 0.
- R2: Groups 0 and 1 never take part in level selection. An enabled request on them leaves `level_o` at 7.
- R3: A group is pending only when its request AND enable (4 bits each) is nonzero. A request without its enable bit has no effect on `level_o`.
- R4: Among pending groups 2..30, the lowest level wins. When levels are equal, the lowest group number wins.
- R5: With no pending group, the selection is group 0 at level 7. A pending group at level 7 never displaces that default.
- R6: `level_o` shows the selection made from the inputs of the previous cycle, one register stage after the inputs change.
- R7: A cycle with `ack_i` high latches the group selected in that cycle. From the next cycle, reading byte 0 gives the group number in bits 6:2, with bits 1:0 and 7 zero.
- R8: Reading byte 0 gives 0 when the latched group's request AND enable has become zero.
- R9: Reading bytes 1, 2 and 3 gives 0.
- R10: An acknowledge whose `ack_lvl_i` differs from the level of the current selection sets `ack_err_o` from the next cycle. The flag stays set until reset, and the group is still latched.
- R11: `nmi_o` pulses high in the cycle after a cycle where `nmi_evt_i[k]` was high and group k had a nonzero request AND enable. An event on a group with nothing pending gives no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | 124 | Request bits, 4 per group |
| en_i | input | 124 | Enable bits, 4 per group |
| lvl_i | input | 93 | Priority level, 3 bits per group |
| nmi_evt_i | input | 2 | Input event strobe for non-maskable groups 0 and 1 |
| ack_i | input | 1 | Processor acknowledge |
| ack_lvl_i | input | 3 | Level the processor is acknowledging |
| rd_byte_i | input | 2 | Byte select of the accepted-group register |
| rd_data_o | output | 8 | Accepted-group read data |
| level_o | output | 3 | Registered level request to the processor |
| nmi_o | output | 1 | Non-maskable interrupt pulse |
| ack_err_o | output | 1 | Sticky acknowledge level mismatch flag |

## Verification
A wrong selection inside the block appears on `level_o` exactly one cycle after the inputs that cause it. It also appears in the group number read back in the cycle after an acknowledge. A fault in the comparison order, such as ties or the level 7 default, therefore appears at most two cycles after the stimulus. A fault in the latch or in the liveness qualification of the readback appears on the very next read. A wrong error flag appears one cycle after the faulty acknowledge and persists after that.

// File: rtl/irq_pri_pkg.sv
package irq_pri_pkg;

    parameter int NUM_GRP     = 31;
    parameter int SRC_PER_GRP = 4;
    parameter int LVL_W       = 3;
    parameter int FIRST_NMI   = 0;
    parameter int LAST_NMI    = 1;
    parameter int FIRST_MASK  = 2;
    parameter int LAST_MASK   = 30;
    parameter int RD_W        = 8;
    parameter int RD_SEL_W    = 2;
    parameter int GRP_SHIFT   = 2;

    localparam int GRP_W   = $clog2(NUM_GRP);
    localparam int NMI_CNT = LAST_NMI - FIRST_NMI + 1;
    localparam int SRC_W   = NUM_GRP * SRC_PER_GRP;
    localparam int LVLV_W  = NUM_GRP * LVL_W;

    typedef logic [GRP_W-1:0] grp_t;
    typedef logic [LVL_W-1:0] lvl_t;

    localparam lvl_t IDLE_LVL = lvl_t'((1 << LVL_W) - 1);

    typedef struct packed {
        grp_t grp;
        lvl_t lvl;
    } choice_t;

    function automatic choice_t idle_choice();
        choice_t c;
        c.grp = grp_t'(FIRST_NMI);
        c.lvl = IDLE_LVL;
        return c;
    endfunction

    function automatic logic [RD_W-1:0] pack_grp(grp_t g);
        return RD_W'(g) << GRP_SHIFT;
    endfunction

endpackage

// File: rtl/irq_pri_search.sv
module irq_pri_search
    import irq_pri_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_GRP-1:0]  pend_i,
    input  logic [LVLV_W-1:0]   lvl_i,
    output choice_t             sel_o
);

    choice_t best;

    always_comb begin
        best = idle_choice();
        for (int g = FIRST_MASK; g <= LAST_MASK; g++) begin
            if (pend_i[g] && (lvl_i[g*LVL_W +: LVL_W] < best.lvl)) begin
                best.lvl = lvl_i[g*LVL_W +: LVL_W];
                best.grp = grp_t'(g);
            end
        end
    end

    assign sel_o = best;

    AST_SEL_MASKABLE: assert property (@(posedge clk) disable iff (rst)
        (sel_o.grp == grp_t'(FIRST_NMI)) || (sel_o.grp >= grp_t'(FIRST_MASK))); // R2

    AST_SEL_PENDING: assert property (@(posedge clk) disable iff (rst)
        (sel_o.grp != grp_t'(FIRST_NMI)) |-> pend_i[sel_o.grp]); // R3

    AST_SEL_IDLE: assert property (@(posedge clk) disable iff (rst)
        (sel_o.grp == grp_t'(FIRST_NMI)) |-> (sel_o.lvl == IDLE_LVL)); // R5

endmodule

// File: rtl/irq_pri_ack.sv
module irq_pri_ack
    import irq_pri_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 ack_i,
    input  lvl_t                 ack_lvl_i,
    input  choice_t              sel_i,
    input  logic [NUM_GRP-1:0]   pend_i,
    input  logic [RD_SEL_W-1:0]  rd_byte_i,
    output logic [RD_W-1:0]      rd_data_o,
    output logic                 ack_err_o
);

    grp_t acc_q;
    logic err_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q <= grp_t'(FIRST_NMI);
            err_q <= 1'b0;
        end else if (ack_i) begin
            acc_q <= sel_i.grp;
            if (ack_lvl_i != sel_i.lvl)
                err_q <= 1'b1;
        end
    end

    always_comb begin
        rd_data_o = '0;
        if (rd_byte_i == '0 && pend_i[acc_q])
            rd_data_o = pack_grp(acc_q);
    end

    assign ack_err_o = err_q;

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
        ack_err_o |=> ack_err_o); // R10

    AST_RD_ALIGNED: assert property (@(posedge clk) disable iff (rst)
        rd_data_o[GRP_SHIFT-1:0] == '0); // R7

endmodule

// File: rtl/irq_pri_nmi.sv
module irq_pri_nmi
    import irq_pri_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [NMI_CNT-1:0] evt_i,
    input  logic [NMI_CNT-1:0] pend_i,
    output logic               nmi_o
);

    logic nmi_q;

    always_ff @(posedge clk) begin
        if (rst) nmi_q <= 1'b0;
        else     nmi_q <= |(evt_i & pend_i);
    end

    assign nmi_o = nmi_q;

    AST_NMI_CAUSE: assert property (@(posedge clk) disable iff (rst)
        nmi_o |-> $past(|evt_i)); // R11

endmodule

// File: rtl/irq_pri_resolver.sv
module irq_pri_resolver
    import irq_pri_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic [SRC_W-1:0]    req_i,
    input  logic [SRC_W-1:0]    en_i,
    input  logic [LVLV_W-1:0]   lvl_i,
    input  logic [NMI_CNT-1:0]  nmi_evt_i,
    input  logic                ack_i,
    input  logic [LVL_W-1:0]    ack_lvl_i,
    input  logic [RD_SEL_W-1:0] rd_byte_i,
    output logic [RD_W-1:0]     rd_data_o,
    output logic [LVL_W-1:0]    level_o,
    output logic                nmi_o,
    output logic                ack_err_o
);

    logic [NUM_GRP-1:0] pend;
    choice_t            sel;
    lvl_t               level_q;

    for (genvar g = 0; g < NUM_GRP; g++) begin : g_pend
        assign pend[g] = |(req_i[g*SRC_PER_GRP +: SRC_PER_GRP] &
                           en_i [g*SRC_PER_GRP +: SRC_PER_GRP]);
    end

    irq_pri_search u_search (
        .clk    (clk),
        .rst    (rst),
        .pend_i (pend),
        .lvl_i  (lvl_i),
        .sel_o  (sel)
    );

    irq_pri_ack u_ack (
        .clk       (clk),
        .rst       (rst),
        .ack_i     (ack_i),
        .ack_lvl_i (ack_lvl_i),
        .sel_i     (sel),
        .pend_i    (pend),
        .rd_byte_i (rd_byte_i),
        .rd_data_o (rd_data_o),
        .ack_err_o (ack_err_o)
    );

    irq_pri_nmi u_nmi (
        .clk    (clk),
        .rst    (rst),
        .evt_i  (nmi_evt_i),
        .pend_i (pend[LAST_NMI:FIRST_NMI]),
        .nmi_o  (nmi_o)
    );

    always_ff @(posedge clk) begin
        if (rst) level_q <= IDLE_LVL;
        else     level_q <= sel.lvl;
    end

    assign level_o = level_q;

    AST_LVL_IDLE: assert property (@(posedge clk) disable iff (rst)
        !(|pend[LAST_MASK:FIRST_MASK]) |=> (level_o == IDLE_LVL)); // R5

endmodule

// File: tb/tb_irq_pri_resolver.sv
module tb_irq_pri_resolver;
    import irq_pri_pkg::*;

    logic                clk = 1'b0;
    logic                rst;
    logic [SRC_W-1:0]    req_v, en_v;
    logic [LVLV_W-1:0]   lvl_v;
    logic [NMI_CNT-1:0]  evt_v;
    logic                ack;
    logic [LVL_W-1:0]    ack_lvl;
    logic [RD_SEL_W-1:0] rd_byte;
    logic [RD_W-1:0]     rd_data;
    logic [LVL_W-1:0]    level;
    logic                nmi;
    logic                ack_err;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    irq_pri_resolver dut (
        .clk(clk), .rst(rst), .req_i(req_v), .en_i(en_v), .lvl_i(lvl_v),
        .nmi_evt_i(evt_v), .ack_i(ack), .ack_lvl_i(ack_lvl), .rd_byte_i(rd_byte),
        .rd_data_o(rd_data), .level_o(level), .nmi_o(nmi), .ack_err_o(ack_err)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic bit pend_of(int g);
        return |(req_v[g*SRC_PER_GRP +: SRC_PER_GRP] & en_v[g*SRC_PER_GRP +: SRC_PER_GRP]);
    endfunction

    function automatic void model(output int g, output int l);
        g = 0; l = 7;
        for (int k = 2; k <= 30; k++) begin
            if (pend_of(k) && int'(lvl_v[k*LVL_W +: LVL_W]) < l) begin
                l = int'(lvl_v[k*LVL_W +: LVL_W]);
                g = k;
            end
        end
    endfunction

    task automatic clear_all();
        req_v = '0; en_v = '0; lvl_v = '1; evt_v = '0; ack = 0; ack_lvl = 0; rd_byte = 0;
    endtask

    task automatic set_grp(int g, logic [3:0] r, logic [3:0] e, logic [2:0] l);
        req_v[g*SRC_PER_GRP +: SRC_PER_GRP] = r;
        en_v [g*SRC_PER_GRP +: SRC_PER_GRP] = e;
        lvl_v[g*LVL_W +: LVL_W] = l;
    endtask

    task automatic step();
        @(posedge clk); #1;
    endtask

    initial begin
        #1_000_000;
        checks++; errors++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int eg, el, pg, pl, exp_nmi;
        void'($urandom(32'd1234));
        clear_all();
        rst = 1;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 0;
        #1;
        check(level == 7, "R1 level", level, 7);
        check(nmi == 0, "R1 nmi", nmi, 0);
        check(ack_err == 0, "R1 err", ack_err, 0);
        check(rd_data == 0, "R1 rd", rd_data, 0);

        // R2: groups 0 and 1 pending at level 0
        @(negedge clk); clear_all(); set_grp(0, 4'hF, 4'hF, 0); set_grp(1, 4'h1, 4'h1, 0);
        step(); check(level == 7, "R2 nmi groups ignored", level, 7);

        // R3: request without enable
        @(negedge clk); clear_all(); set_grp(12, 4'h5, 4'hA, 1);
        step(); check(level == 7, "R3 unenabled request", level, 7);
        @(negedge clk); set_grp(12, 4'h5, 4'h4, 1);
        #1 check(level == 7, "R6 level before edge", level, 7);
        step(); check(level == 1, "R3 R6 enabled request", level, 1);

        // R4: tie on level 2 between groups 9 and 4
        @(negedge clk); clear_all(); set_grp(9, 4'h1, 4'h1, 2); set_grp(4, 4'h8, 4'h8, 2);
        set_grp(20, 4'h2, 4'h2, 3); ack = 1; ack_lvl = 2;
        step(); check(level == 2, "R4 tie level", level, 2);
        check(rd_data == 8'd16, "R4 R7 tie winner group 4", rd_data, 16);

        // R9: other bytes read zero
        for (int b = 1; b < 4; b++) begin
            @(negedge clk); ack = 0; rd_byte = RD_SEL_W'(b);
            #1 check(rd_data == 0, "R9 upper byte", rd_data, 0);
        end

        // R8: latched group loses its enable
        @(negedge clk); rd_byte = 0; set_grp(4, 4'h8, 4'h0, 2);
        #1 check(rd_data == 0, "R8 vanished request", rd_data, 0);

        // R5: pending only at level 7 -> default kept
        @(negedge clk); clear_all(); set_grp(30, 4'hF, 4'hF, 7); ack = 1; ack_lvl = 7;
        step(); check(level == 7, "R5 level 7 pending", level, 7);
        @(negedge clk); ack = 0;
        #1 check(rd_data == 0, "R5 accepted default group", rd_data, 0);

        // R11: NMI events
        @(negedge clk); clear_all(); set_grp(1, 4'h2, 4'h2, 0); evt_v = 2'b01;
        step(); check(nmi == 0, "R11 event on idle group", nmi, 0);
        @(negedge clk); evt_v = 2'b10;
        step(); check(nmi == 1, "R11 event on pending group", nmi, 1);
        @(negedge clk); evt_v = 2'b00;
        step(); check(nmi == 0, "R11 single pulse", nmi, 0);

        // Random mix covering R3 R4 R6 R7 R11
        for (int it = 0; it < 400; it++) begin
            @(negedge clk);
            for (int w = 0; w < SRC_W; w += 32) begin
                logic [31:0] a, b, c;
                a = $urandom(); b = $urandom(); c = $urandom();
                for (int k = 0; k < 32; k++) if (w + k < SRC_W) begin
                    req_v[w+k] = a[k];
                    en_v[w+k]  = b[k] & c[k] & (it[0] | a[(k+3)%32]);
                end
            end
            for (int k = 0; k < LVLV_W; k++) lvl_v[k] = 1'($urandom() & 1);
            evt_v = NMI_CNT'($urandom());
            rd_byte = 0;
            model(eg, el);
            ack = 1'($urandom() & 1);
            ack_lvl = LVL_W'(el);
            exp_nmi = int'(|({pend_of(1), pend_of(0)} & evt_v));
            step();
            check(int'(level) == el, "R4 R6 random level", level, el);
            check(int'(nmi) == exp_nmi, "R11 random nmi", nmi, exp_nmi);
            if (ack) check(int'(rd_data) == eg * 4, "R7 random readback", rd_data, eg * 4);
            pg = eg; pl = el;
        end
        check(ack_err == 0, "R10 no error on matching acks", ack_err, 0);

        // R10: mismatching acknowledge
        @(negedge clk); clear_all(); set_grp(17, 4'h4, 4'h4, 3); ack = 1; ack_lvl = 5;
        step(); check(ack_err == 1, "R10 mismatch sets flag", ack_err, 1);
        check(rd_data == 8'd68, "R10 group still latched", rd_data, 68);
        @(negedge clk); clear_all();
        step(); step();
        check(ack_err == 1, "R10 flag sticky", ack_err, 1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule